// File: doc/BRIEF.md
# Sample-and-Convert Sequencer

This block paces the sample-and-convert cycle of a successive-approximation converter. After acquisition has run for a parameterised number of clocks, it puts the sampler into hold, raises BUSY for a fixed conversion time, and then publishes the held sample as the result. It also emits a one-cycle result-ready strobe in the same cycle that BUSY drops. The bit decisions themselves are not modelled. The value on the sample port is captured at the hold instant and released when the conversion window closes.

The start input picks between two modes. If it is low when acquisition runs out, the hold happens at once. If it is high, the sequencer parks and waits for a falling edge on it, which lets the system place the sampling instant with low jitter. A synchronous reset aborts any conversion in progress. A power-down input stops new conversions but lets a running one finish.

Top module: `conv_seq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy_o` and `result_vld_o` are 0 and `result_o` is all zeros.
- R2: Acquisition lasts ACQ_CYC clock edges after it begins. If `cnv_start_i` is low at the last of these edges, that edge is the hold edge and `busy_o` is 1 in the following cycle.
- R3: If `cnv_start_i` is high at the last acquisition edge, the sequencer waits. The hold edge is then the first edge at which `cnv_start_i` is 0 while it was 1 at the edge before.
- R4: `busy_o` stays high for exactly CNV_CYC consecutive cycles for each conversion that is not aborted.
- R5: In the cycle in which `busy_o` falls, `result_vld_o` is 1 for that one cycle only. `result_o` then equals the `sample_i` value present at the hold edge.
- R6: When a conversion completes, acquisition starts again. With `cnv_start_i` held low, holds follow one another every ACQ_CYC + CNV_CYC edges.
- R7: A high `rst` during a conversion drops `busy_o` after the next edge. It clears `result_o`, and no `result_vld_o` pulse follows for the aborted conversion.
- R8: While `pwr_dn_i` is high and no conversion is running, no conversion starts, whether the sequencer is acquiring or waiting for an edge. When `pwr_dn_i` goes low, a full acquisition of ACQ_CYC edges follows before the next hold.
- R9: A conversion that is running when `pwr_dn_i` rises completes normally with its result and strobe. After it, no conversion starts until `pwr_dn_i` falls.
- R10: `result_o` changes only on the cycle in which `result_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every count is in its cycles |
| rst | input | 1 | Synchronous reset, active high; also aborts a conversion |
| cnv_start_i | input | 1 | Start level / start edge (falling edge starts in wait mode) |
| pwr_dn_i | input | 1 | Power-down request, active high |
| sample_i | input | DATA_W | Sample value presented for capture at the hold edge |
| busy_o | output | 1 | High while a conversion runs |
| result_o | output | DATA_W | Last completed conversion result |
| result_vld_o | output | 1 | One-cycle strobe coinciding with the fall of busy_o |

## Verification
On every cycle the assertions check several properties that hold regardless of stimulus. These are the length of each BUSY window, that a hold is always followed by BUSY, that the strobe lines up with BUSY falling and follows a completed count, that the result is stable between strobes, and that power-down never lets BUSY rise. The bench scenarios show the behaviour that depends on stimulus history. This includes the choice between immediate and edge-started holds as the start input's drop point is swept across the acquisition boundary, which sample value gets captured, the abort path through reset, and the full fresh acquisition that follows power-down.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_PDN  = 2'd3
  } seq_state_t;

  // Bits needed to count 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Edge-start detection: previous level high, current level low.
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Length of one unblocked cycle of the immediate-start mode.
  function automatic int unsigned period(input int unsigned acq, input int unsigned cnv);
    return acq + cnv;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned W = conv_seq_pkg::cnt_width(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/start_fall_det.sv
module start_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign fall = conv_seq_pkg::is_fall(din_q, din);
endmodule

// File: rtl/sample_latch.sv
module sample_latch #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              publish,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      result <= '0;
    end else begin
      if (hold)    held_q <= sample;
      if (publish) result <= held_q;
    end
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACQ_CYC = 8,
  parameter int unsigned CNV_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_start_i,
  input  logic              pwr_dn_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o
);
  import conv_seq_pkg::*;

  seq_state_t st, st_nx;

  // Named internal events, also observed by the bound checker.
  logic acq_done;
  logic cnv_done;
  logic start_fall;
  logic hold_evt;

  seq_timer #(.LEN(ACQ_CYC)) u_acq_tmr (
    .clk (clk),
    .rst (rst),
    .run (st == ST_ACQ),
    .done(acq_done)
  );

  seq_timer #(.LEN(CNV_CYC)) u_cnv_tmr (
    .clk (clk),
    .rst (rst),
    .run (st == ST_CONV),
    .done(cnv_done)
  );

  start_fall_det u_fall (
    .clk (clk),
    .rst (rst),
    .din (cnv_start_i),
    .fall(start_fall)
  );

  assign hold_evt = !pwr_dn_i &&
                    (((st == ST_ACQ) && acq_done && !cnv_start_i) ||
                     ((st == ST_WAIT) && start_fall));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_ACQ: begin
        if (pwr_dn_i)      st_nx = ST_PDN;
        else if (acq_done) st_nx = cnv_start_i ? ST_WAIT : ST_CONV;
      end
      ST_WAIT: begin
        if (pwr_dn_i)        st_nx = ST_PDN;
        else if (start_fall) st_nx = ST_CONV;
      end
      ST_CONV: begin
        if (cnv_done) st_nx = pwr_dn_i ? ST_PDN : ST_ACQ;
      end
      ST_PDN: begin
        if (!pwr_dn_i) st_nx = ST_ACQ;
      end
      default: st_nx = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_ACQ;
      result_vld_o <= 1'b0;
    end else begin
      st           <= st_nx;
      result_vld_o <= cnv_done;
    end
  end

  sample_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold_evt),
    .publish(cnv_done),
    .sample (sample_i),
    .result (result_o)
  );

  assign busy_o = (st == ST_CONV);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNV_CYC = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_dn_i,
  input logic              busy_o,
  input logic              result_vld_o,
  input logic [DATA_W-1:0] result_o,
  input logic              cnv_done,
  input logic              hold_evt
);
  localparam int unsigned BW = conv_seq_pkg::cnt_width(CNV_CYC + 1);

  logic [BW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_len <= '0;
    else                busy_len <= busy_len + 1'b1;
  end

  // R4: the count ends exactly on the CNV_CYC-th busy cycle
  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    cnv_done |-> (busy_o && busy_len == BW'(CNV_CYC - 1)));

  // R2 / R3: a hold is always followed by busy
  p_hold_busy_r2: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> busy_o);

  // R5: strobe coincides with the fall of busy
  p_vld_fall_r5: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> (!busy_o && $past(busy_o)));

  // R7: a strobe only follows a completed count
  p_vld_done_r7: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> $past(cnv_done));

  // R8: power-down keeps an idle sequencer idle
  p_pd_block_r8: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn_i && !busy_o) |=> !busy_o);

  // R10: result only moves with the strobe
  p_result_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!result_vld_o && !$past(rst)) |-> $stable(result_o));
endmodule

bind conv_seq_top conv_seq_chk #(.DATA_W(DATA_W), .CNV_CYC(CNV_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_dn_i    (pwr_dn_i),
  .busy_o      (busy_o),
  .result_vld_o(result_vld_o),
  .result_o    (result_o),
  .cnv_done    (cnv_done),
  .hold_evt    (hold_evt)
);

// File: tb/sim_conv_seq_top.sv
module sim_conv_seq_top;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int A     = 6;
  localparam int C     = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnv = 1'b0;
  logic         pd  = 1'b0;
  logic [W-1:0] smp = '0;
  logic         busy, vld;
  logic [W-1:0] res;

  int k = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  conv_seq_top #(.DATA_W(W), .ACQ_CYC(A), .CNV_CYC(C)) u0 (
    .clk(clk), .rst(rst), .cnv_start_i(cnv), .pwr_dn_i(pd),
    .sample_i(smp), .busy_o(busy), .result_o(res), .result_vld_o(vld)
  );

  function automatic logic [W-1:0] pat(input int n);
    return W'((n * 40503 + 4660) ^ (n << 9));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual %0h expected %0h", req, what, k, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    k++;
    smp = pat(k);
  endtask

  task automatic do_reset(input bit lvl);
    rst = 1'b1; cnv = lvl; pd = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(vld == 1'b0,  "R1", "vld",  int'(vld), 0);
    chk(res == '0,    "R1", "result", int'(res), 0);
    rst = 1'b0;
    k = 0;
    smp = pat(0);
  endtask

  // Runs up to and including the strobe of a conversion whose hold edge is h.
  task automatic expect_conv(input int h, input int drop_at, input int pd_at, input string req);
    while (k < h + C) begin
      step();
      if (k == drop_at) cnv = 1'b0;
      if (k == pd_at)   pd  = 1'b1;
      chk(busy == ((k >= h) && (k < h + C)), "R4", "busy", int'(busy), int'((k >= h) && (k < h + C)));
      chk(vld == (k == h + C), "R5", "vld", int'(vld), int'(k == h + C));
      if (k == h + C) chk(res == pat(h - 1), req, "result", int'(res), int'(pat(h - 1)));
    end
  endtask

  task automatic idle_until(input int stop, input string req);
    while (k < stop) begin
      step();
      chk(busy == 1'b0 && vld == 1'b0, req, "idle busy/vld", int'({busy, vld}), 0);
    end
  endtask

  initial begin
    #(CLK_P * 60000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R2, R6: immediate mode, three back-to-back conversions
    do_reset(1'b0);
    expect_conv(A, -1, -1, "R2");
    expect_conv(2*A + C, -1, -1, "R6");
    expect_conv(3*A + 2*C, -1, -1, "R6");

    // R2 / R3: sweep the start drop point across the acquisition boundary
    for (int f = 1; f <= A + 6; f++) begin
      do_reset(1'b1);
      expect_conv((f + 1 > A) ? f + 1 : A, f, -1, (f < A) ? "R2" : "R3");
    end

    // R7: abort in mid-conversion
    do_reset(1'b0);
    while (k < A + 2) step();
    chk(busy == 1'b1, "R7", "busy before abort", int'(busy), 1);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(busy == 1'b0 && vld == 1'b0, "R7", "abort busy/vld", int'({busy, vld}), 0);
      chk(res == '0, "R7", "abort result", int'(res), 0);
    end

    // R8: power-down during acquisition, then a fresh acquisition
    do_reset(1'b0);
    step(); step();
    pd = 1'b1;
    idle_until(30, "R8");
    pd = 1'b0;
    expect_conv(30 + 1 + A, -1, -1, "R8");

    // R8: power-down while waiting for the start edge; the edge is ignored
    do_reset(1'b1);
    while (k < A + 2) step();
    pd = 1'b1;
    idle_until(A + 4, "R8");
    cnv = 1'b0;
    idle_until(A + 15, "R8");
    pd = 1'b0;
    expect_conv(A + 16 + A, -1, -1, "R8");

    // R9: power-down raised mid-conversion; conversion completes, then blocks
    do_reset(1'b0);
    expect_conv(A, -1, A + 1, "R9");
    idle_until(A + C + 20, "R9");
    chk(res == pat(A - 1), "R10", "result held", int'(res), int'(pat(A - 1)));
    pd = 1'b0;
    expect_conv(A + C + 20 + 1 + A, -1, -1, "R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule